// File: doc/BRIEF.md
# Isochronous Ping-Pong Receive Buffer

This block buffers the payload of one isochronous OUT endpoint. The host may deliver its packet at any moment inside a 1 ms frame, and no handshake or per-packet interrupt tells the CPU that it has arrived. For this reason the buffer has two equal banks. The bus side fills the background bank and the CPU drains the foreground bank. On every start-of-frame pulse the two banks trade roles. The packet that arrived during the frame just ended is therefore handed to software as a whole on the frame tick.

The CPU side shows an empty flag and a byte count for its bank, so software can read the bank to the end after each frame tick. Reads act only while the CPU holds the bank through a select/release handshake. They return data one cycle after the read strobe. Two sticky error flags, each cleared by the CPU, record events that are otherwise silent: a write past the configured size (overrun) and a read of an empty bank (underrun). The configured packet size is a run-time input, clamped to the per-bank depth parameter.

Top module: `iso_pingpong_rx`

## Requirements
- R1: After reset, bank 0 is foreground (`fg_bank`=0), `fg_empty`=1, `fg_count`=0, `cpu_owned`=0, `ovr_flag`=0, `udr_flag`=0 and `cpu_rdata`=0.
- R2: A byte accepted by `bus_wr` is stored in the background bank at the next free position. Bytes come back in write order once that bank becomes foreground.
- R3: Each cycle with `sof`=1 inverts `fg_bank` at that clock edge.
- R4: After a swap, `fg_count` equals the number of bytes accepted into that bank during the frame just ended. The read position restarts at 0. `fg_count` does not change between swaps.
- R5: The bank that becomes background on a swap starts empty. A frame with no accepted writes therefore yields `fg_count`=0 and `fg_empty`=1 after the next swap.
- R6: The write limit is the smaller of `pkt_size` and the depth parameter. A write to an open background bank already holding that many bytes is dropped and sets `ovr_flag` one cycle later.
- R7: `ovr_flag` stays set until a cycle with `ovr_clr`=1 and no new overrun. A new overrun in the same cycle as the clear wins.
- R8: `bus_eop` closes the background bank for the rest of the frame. Later writes in that frame are dropped without setting `ovr_flag`. A write in the same cycle as `bus_eop` is still accepted.
- R9: An accepted read places the next unread foreground byte on `cpu_rdata` one cycle later. `fg_empty`=1 once every counted byte has been read.
- R10: An accepted read while `fg_empty`=1 puts 0 on `cpu_rdata` and sets `udr_flag`.
- R11: `udr_clr` clears `udr_flag`. A new underrun in the same cycle wins.
- R12: `cpu_sel` sets `cpu_owned` and `cpu_rel` clears it, with `cpu_sel` winning if both are high. A `cpu_rd` is accepted only while `cpu_owned`=1 and `sof`=0. An ignored read leaves `cpu_rdata` and the read position unchanged.
- R13: A write in the same cycle as `sof` lands in the bank that becomes foreground, and it is included in that bank's `fg_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Start-of-frame pulse; swaps the banks |
| pkt_size | input | SIZE_W | Configured packet size in bytes |
| bus_wr | input | 1 | Bus-side write strobe |
| bus_data | input | DATA_W | Bus-side write byte |
| bus_eop | input | 1 | End-of-packet strobe; closes the background bank |
| cpu_sel | input | 1 | CPU takes the foreground bank |
| cpu_rel | input | 1 | CPU releases the foreground bank |
| cpu_rd | input | 1 | CPU read strobe |
| ovr_clr | input | 1 | Clears the overrun flag |
| udr_clr | input | 1 | Clears the underrun flag |
| cpu_rdata | output | DATA_W | Byte returned by the last accepted read |
| fg_empty | output | 1 | No unread bytes in the foreground bank |
| fg_count | output | CNT_W | Byte count held by the foreground bank |
| fg_bank | output | 1 | Index of the foreground bank |
| cpu_owned | output | 1 | CPU currently holds the foreground bank |
| ovr_flag | output | 1 | Sticky overrun flag |
| udr_flag | output | 1 | Sticky underrun flag |

## Verification
The assertions check, on every cycle, the local rules:
- the role flip on each frame tick;
- the frozen count between ticks;
- the emptying of the bank that turns background;
- the setting of both sticky flags;
- the zero returned by an empty read;
- the stillness of the read data when a read is refused;
- the read position staying within the count.

Only the bench scenarios can show the end-to-end properties. These are that bytes come back in their write order one frame later, that the size clamp and the end-of-packet close cut the frame at the right byte, and that a write coinciding with the frame tick is counted in the bank handed over.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;

   typedef enum logic {
      BANK_LO = 1'b0,
      BANK_HI = 1'b1
   } bank_e;

   // Smaller of the requested packet size and the bank capacity
   function automatic int unsigned clamp_len(input int unsigned req, input int unsigned cap);
      return (req > cap) ? cap : req;
   endfunction

endpackage

// File: rtl/iso_rx_bank_ctl.sv
module iso_rx_bank_ctl #(
   parameter int MAX_BYTES = 64,
   parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             is_bg,
   input  logic             swap,
   input  logic             wr_req,
   input  logic             eop,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] count,
   output logic             accept,
   output logic             overflow
);

   logic [CNT_W-1:0] cnt_q;
   logic             closed_q;
   logic             open_w;
   logic             room_w;

   assign open_w   = is_bg & wr_req & ~closed_q;
   assign room_w   = (cnt_q < limit);
   assign accept   = open_w & room_w;
   assign overflow = open_w & ~room_w;
   assign count    = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         closed_q <= 1'b0;
      end else if (swap && !is_bg) begin
         // foreground bank about to take the bus side: discard old frame
         cnt_q    <= '0;
         closed_q <= 1'b0;
      end else begin
         if (accept) cnt_q <= cnt_q + 1'b1;
         if (is_bg && eop) closed_q <= 1'b1;
      end
   end

   a_r5_bank_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (swap && !is_bg) |=> (count == '0));

   a_r6_within_depth: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (count <= CNT_W'(MAX_BYTES)));

endmodule

// File: rtl/iso_rx_store.sv
module iso_rx_store #(
   parameter int DATA_W    = 8,
   parameter int MAX_BYTES = 64,
   parameter int PTR_W     = $clog2(MAX_BYTES)
) (
   input  logic              clk,
   input  logic              we,
   input  logic              wbank,
   input  logic [PTR_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rbank,
   input  logic [PTR_W-1:0]  raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 2 * MAX_BYTES;

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem_q[{wbank, waddr}] <= wdata;
   end

   assign rdata = mem_q[{rbank, raddr}];

endmodule

// File: rtl/iso_rx_cpu_port.sv
module iso_rx_cpu_port #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              swap,
   input  logic              sel,
   input  logic              rel,
   input  logic              rd,
   input  logic              udr_clr,
   input  logic [CNT_W-1:0]  fg_count,
   input  logic [DATA_W-1:0] mem_q,
   output logic [CNT_W-1:0]  rptr,
   output logic [DATA_W-1:0] rdata,
   output logic              empty,
   output logic              udr,
   output logic              owned
);

   logic [CNT_W-1:0]  rptr_q;
   logic [DATA_W-1:0] rdata_q;
   logic              owned_q;
   logic              udr_q;
   logic              rd_go;
   logic              udr_hit;

   assign empty   = (rptr_q >= fg_count);
   assign rd_go   = owned_q & rd & ~swap;
   assign udr_hit = rd_go & empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rptr_q  <= '0;
         rdata_q <= '0;
         owned_q <= 1'b0;
         udr_q   <= 1'b0;
      end else begin
         if (sel)      owned_q <= 1'b1;
         else if (rel) owned_q <= 1'b0;

         if (swap) begin
            rptr_q <= '0;
         end else if (rd_go) begin
            if (empty) begin
               rdata_q <= '0;
            end else begin
               rdata_q <= mem_q;
               rptr_q  <= rptr_q + 1'b1;
            end
         end

         udr_q <= udr_hit | (udr_q & ~udr_clr);
      end
   end

   assign rptr  = rptr_q;
   assign rdata = rdata_q;
   assign udr   = udr_q;
   assign owned = owned_q;

   a_r10_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_go && empty) |=> (udr && rdata == '0));

   a_r12_refused_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !(owned && !swap)) |=> $stable(rdata));

   a_r9_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
      !swap |=> (rptr <= fg_count));

   a_r11_udr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (udr_clr && !rd) |=> !udr);

endmodule

// File: rtl/iso_pingpong_rx.sv
module iso_pingpong_rx
   import iso_rx_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int MAX_BYTES = 64,
   parameter int SIZE_W    = 10
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 sof,
   input  logic [SIZE_W-1:0]                    pkt_size,
   input  logic                                 bus_wr,
   input  logic [DATA_W-1:0]                    bus_data,
   input  logic                                 bus_eop,
   input  logic                                 cpu_sel,
   input  logic                                 cpu_rel,
   input  logic                                 cpu_rd,
   input  logic                                 ovr_clr,
   input  logic                                 udr_clr,
   output logic [DATA_W-1:0]                    cpu_rdata,
   output logic                                 fg_empty,
   output logic [$clog2(MAX_BYTES + 1)-1:0]     fg_count,
   output logic                                 fg_bank,
   output logic                                 cpu_owned,
   output logic                                 ovr_flag,
   output logic                                 udr_flag
);

   localparam int CNT_W  = $clog2(MAX_BYTES + 1);
   localparam int PTR_W  = $clog2(MAX_BYTES);
   localparam int NBANKS = 2;

   generate
      if (MAX_BYTES < 2 || (1 << PTR_W) != MAX_BYTES)
         $error("MAX_BYTES must be a power of two of at least 2");
      if (MAX_BYTES >= (1 << SIZE_W))
         $error("MAX_BYTES must fit in SIZE_W bits");
      if (DATA_W < 1)
         $error("DATA_W must be positive");
   endgenerate

   bank_e             fg_q;
   logic              bg_idx;
   logic [CNT_W-1:0]  limit;
   logic [CNT_W-1:0]  bank_cnt [NBANKS];
   logic [NBANKS-1:0] bank_acc;
   logic [NBANKS-1:0] bank_ovf;
   logic              ovr_hit;
   logic              ovr_q;
   logic [CNT_W-1:0]  rptr;
   logic [DATA_W-1:0] mem_q;
   logic [CNT_W-1:0]  fg_cnt_w;
   logic [CNT_W-1:0]  bg_cnt_w;

   assign bg_idx  = ~fg_q;
   assign limit   = CNT_W'(clamp_len(int'(pkt_size), MAX_BYTES));
   assign ovr_hit = |bank_ovf;

   for (genvar b = 0; b < NBANKS; b++) begin : g_bank
      logic is_bg;
      assign is_bg = (fg_q != bank_e'(b));

      iso_rx_bank_ctl #(
         .MAX_BYTES (MAX_BYTES),
         .CNT_W     (CNT_W)
      ) i_ctl (
         .clk      (clk),
         .rst_n    (rst_n),
         .is_bg    (is_bg),
         .swap     (sof),
         .wr_req   (bus_wr),
         .eop      (bus_eop),
         .limit    (limit),
         .count    (bank_cnt[b]),
         .accept   (bank_acc[b]),
         .overflow (bank_ovf[b])
      );
   end

   assign fg_cnt_w = bank_cnt[fg_q];
   assign bg_cnt_w = bank_cnt[bg_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fg_q  <= BANK_LO;
         ovr_q <= 1'b0;
      end else begin
         if (sof) fg_q <= bank_e'(bg_idx);
         ovr_q <= ovr_hit | (ovr_q & ~ovr_clr);
      end
   end

   iso_rx_store #(
      .DATA_W    (DATA_W),
      .MAX_BYTES (MAX_BYTES),
      .PTR_W     (PTR_W)
   ) i_store (
      .clk   (clk),
      .we    (|bank_acc),
      .wbank (bg_idx),
      .waddr (bg_cnt_w[PTR_W-1:0]),
      .wdata (bus_data),
      .rbank (fg_q),
      .raddr (rptr[PTR_W-1:0]),
      .rdata (mem_q)
   );

   iso_rx_cpu_port #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) i_cpu (
      .clk      (clk),
      .rst_n    (rst_n),
      .swap     (sof),
      .sel      (cpu_sel),
      .rel      (cpu_rel),
      .rd       (cpu_rd),
      .udr_clr  (udr_clr),
      .fg_count (fg_cnt_w),
      .mem_q    (mem_q),
      .rptr     (rptr),
      .rdata    (cpu_rdata),
      .empty    (fg_empty),
      .udr      (udr_flag),
      .owned    (cpu_owned)
   );

   assign fg_count = fg_cnt_w;
   assign fg_bank  = fg_q;
   assign ovr_flag = ovr_q;

   a_r3_swap: assert property (@(posedge clk) disable iff (!rst_n)
      sof |=> (fg_bank != $past(fg_bank)));

   a_r4_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !sof |=> $stable(fg_count));

   a_r6_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_hit |=> ovr_flag);

   a_r7_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_clr && !ovr_hit) |=> !ovr_flag);

   a_r2_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_acc));

endmodule

// File: tb/test_iso_pingpong_rx.sv
module test_iso_pingpong_rx;

   localparam int CLK_PER = 10;
   localparam int DW      = 8;
   localparam int MAXB    = 16;
   localparam int SW      = 10;
   localparam int CW      = $clog2(MAXB + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sof = 1'b0;
   logic [SW-1:0] pkt_size = SW'(8);
   logic          bus_wr = 1'b0;
   logic [DW-1:0] bus_data = '0;
   logic          bus_eop = 1'b0;
   logic          cpu_sel = 1'b0;
   logic          cpu_rel = 1'b0;
   logic          cpu_rd = 1'b0;
   logic          ovr_clr = 1'b0;
   logic          udr_clr = 1'b0;
   logic [DW-1:0] cpu_rdata;
   logic          fg_empty;
   logic [CW-1:0] fg_count;
   logic          fg_bank;
   logic          cpu_owned;
   logic          ovr_flag;
   logic          udr_flag;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   iso_pingpong_rx #(.DATA_W(DW), .MAX_BYTES(MAXB), .SIZE_W(SW)) i_iso_pingpong_rx (
      .clk(clk), .rst_n(rst_n), .sof(sof), .pkt_size(pkt_size),
      .bus_wr(bus_wr), .bus_data(bus_data), .bus_eop(bus_eop),
      .cpu_sel(cpu_sel), .cpu_rel(cpu_rel), .cpu_rd(cpu_rd),
      .ovr_clr(ovr_clr), .udr_clr(udr_clr), .cpu_rdata(cpu_rdata),
      .fg_empty(fg_empty), .fg_count(fg_count), .fg_bank(fg_bank),
      .cpu_owned(cpu_owned), .ovr_flag(ovr_flag), .udr_flag(udr_flag)
   );

   always #(CLK_PER / 2) clk = ~clk;

   // Behavioural reference model
   int m_fg, m_rp, m_rdata;
   int m_cnt [2];
   bit m_closed [2];
   int m_mem [2][MAXB];
   bit m_sel, m_ovr, m_udr;

   task automatic model_step();
      int bg, lim;
      bit ovr_set, udr_set, go;
      if (!rst_n) begin
         m_fg = 0; m_rp = 0; m_rdata = 0; m_sel = 0; m_ovr = 0; m_udr = 0;
         m_cnt[0] = 0; m_cnt[1] = 0; m_closed[0] = 0; m_closed[1] = 0;
         return;
      end
      bg = 1 - m_fg;
      lim = (int'(pkt_size) > MAXB) ? MAXB : int'(pkt_size);
      ovr_set = 0; udr_set = 0;
      if (bus_wr && !m_closed[bg]) begin
         if (m_cnt[bg] < lim) begin
            m_mem[bg][m_cnt[bg]] = int'(bus_data);
            m_cnt[bg]++;
         end else ovr_set = 1;
      end
      if (bus_eop) m_closed[bg] = 1;
      go = m_sel && cpu_rd && !sof;
      if (go) begin
         if (m_rp < m_cnt[m_fg]) begin
            m_rdata = m_mem[m_fg][m_rp];
            m_rp++;
         end else begin
            m_rdata = 0;
            udr_set = 1;
         end
      end
      m_ovr = ovr_set || (m_ovr && !ovr_clr);
      m_udr = udr_set || (m_udr && !udr_clr);
      if (cpu_sel) m_sel = 1;
      else if (cpu_rel) m_sel = 0;
      if (sof) begin
         m_cnt[m_fg] = 0;
         m_closed[m_fg] = 0;
         m_fg = bg;
         m_rp = 0;
      end
   endtask

   task automatic check_val(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      model_step();
      #(CLK_PER / 4);
      if (rst_n && !done) begin
         check_val("R3 model fg_bank", int'(fg_bank), m_fg);
         check_val("R4 model fg_count", int'(fg_count), m_cnt[m_fg]);
         check_val("R9 model fg_empty", int'(fg_empty), int'(m_rp >= m_cnt[m_fg]));
         check_val("R9 model cpu_rdata", int'(cpu_rdata), m_rdata);
         check_val("R6 model ovr_flag", int'(ovr_flag), int'(m_ovr));
         check_val("R10 model udr_flag", int'(udr_flag), int'(m_udr));
         check_val("R12 model cpu_owned", int'(cpu_owned), int'(m_sel));
      end
   end

   task automatic wr_byte(input int d);
      @(negedge clk); bus_wr = 1'b1; bus_data = DW'(d);
      @(negedge clk); bus_wr = 1'b0;
   endtask
   task automatic pulse_sof();
      @(negedge clk); sof = 1'b1; @(negedge clk); sof = 1'b0;
   endtask
   task automatic pulse_rd();
      @(negedge clk); cpu_rd = 1'b1; @(negedge clk); cpu_rd = 1'b0;
   endtask
   task automatic pulse_sel();
      @(negedge clk); cpu_sel = 1'b1; @(negedge clk); cpu_sel = 1'b0;
   endtask
   task automatic pulse_rel();
      @(negedge clk); cpu_rel = 1'b1; @(negedge clk); cpu_rel = 1'b0;
   endtask
   task automatic pulse_eop();
      @(negedge clk); bus_eop = 1'b1; @(negedge clk); bus_eop = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_PER * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      int saved;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check_val("R1 fg_bank", int'(fg_bank), 0);
      check_val("R1 fg_empty", int'(fg_empty), 1);
      check_val("R1 fg_count", int'(fg_count), 0);
      check_val("R1 flags", int'({cpu_owned, ovr_flag, udr_flag}), 0);
      check_val("R1 cpu_rdata", int'(cpu_rdata), 0);

      // R2 R3 R4 R9: one packet, swap, drain in order
      pulse_sel();
      for (int i = 0; i < 5; i++) wr_byte(16 + i);
      pulse_sof();
      check_val("R3 fg_bank after swap", int'(fg_bank), 1);
      check_val("R4 fg_count", int'(fg_count), 5);
      for (int i = 0; i < 5; i++) begin
         pulse_rd();
         check_val("R2 read order", int'(cpu_rdata), 16 + i);
      end
      check_val("R9 empty after drain", int'(fg_empty), 1);
      // R10 empty read, R11 clear
      pulse_rd();
      check_val("R10 rdata zero", int'(cpu_rdata), 0);
      check_val("R10 udr set", int'(udr_flag), 1);
      @(negedge clk); udr_clr = 1'b1; @(negedge clk); udr_clr = 1'b0;
      check_val("R11 udr cleared", int'(udr_flag), 0);

      // R6 R7 overrun with pkt_size 6
      pkt_size = SW'(6);
      for (int i = 0; i < 9; i++) wr_byte(32 + i);
      check_val("R6 ovr set", int'(ovr_flag), 1);
      @(negedge clk); ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
      check_val("R7 ovr cleared", int'(ovr_flag), 0);
      pulse_sof();
      check_val("R6 count clamped", int'(fg_count), 6);
      for (int i = 0; i < 6; i++) pulse_rd();
      check_val("R6 last kept byte", int'(cpu_rdata), 37);

      // R8 end of packet closes the bank
      pkt_size = SW'(8);
      for (int i = 0; i < 3; i++) wr_byte(48 + i);
      pulse_eop();
      wr_byte(99); wr_byte(98);
      check_val("R8 no overrun", int'(ovr_flag), 0);
      pulse_sof();
      check_val("R8 count stops at eop", int'(fg_count), 3);

      // R12 reads ignored while released
      pulse_rel();
      saved = int'(cpu_rdata);
      pulse_rd();
      check_val("R12 rdata unchanged", int'(cpu_rdata), saved);
      check_val("R12 bank still full", int'(fg_empty), 0);
      pulse_sel();
      pulse_rd();
      check_val("R12 first byte after select", int'(cpu_rdata), 48);

      // R13 write coinciding with frame tick
      wr_byte(64); wr_byte(65);
      @(negedge clk); bus_wr = 1'b1; bus_data = DW'(66); sof = 1'b1;
      @(negedge clk); bus_wr = 1'b0; sof = 1'b0;
      check_val("R13 count includes tick write", int'(fg_count), 3);
      for (int i = 0; i < 3; i++) pulse_rd();
      check_val("R13 tick byte last", int'(cpu_rdata), 66);

      // R5 stale data discarded
      pulse_sof();
      pulse_sof();
      check_val("R5 count zero", int'(fg_count), 0);
      check_val("R5 empty", int'(fg_empty), 1);

      // R6 size above depth clamps to depth
      pkt_size = SW'(100);
      for (int i = 0; i < 20; i++) wr_byte(i);
      check_val("R6 depth overrun", int'(ovr_flag), 1);
      pulse_sof();
      check_val("R6 count at depth", int'(fg_count), MAXB);

      // Mixed traffic against the model
      for (int c = 0; c < 2000; c++) begin
         @(negedge clk);
         sof      = ((c % 37) == 36);
         bus_wr   = ($urandom % 3) == 0;
         bus_data = DW'($urandom);
         bus_eop  = ($urandom % 29) == 0;
         cpu_rd   = ($urandom % 2) == 0;
         cpu_sel  = ($urandom % 23) == 0;
         cpu_rel  = ($urandom % 31) == 0;
         ovr_clr  = ($urandom % 17) == 0;
         udr_clr  = ($urandom % 13) == 0;
         if ((c % 200) == 0) pkt_size = SW'($urandom % 24);
      end
      @(negedge clk);
      {sof, bus_wr, bus_eop, cpu_rd, cpu_sel, cpu_rel, ovr_clr, udr_clr} = '0;
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule